// File: doc/BRIEF.md
# Stationary-Frame Current and Voltage Transform

This block converts one sample of motor phase measurements into orthogonal stationary-frame (d/q) quantities for a torque and flux estimator. Two phase currents give the d and q stator currents. The DC-link voltage and the three inverter leg states give the d and q stator voltages. All scaling uses fixed constant multipliers followed by a fixed bit-slice cut. Nothing is rounded.

A one-cycle strobe starts each sample. On that clock edge a small two-state controller captures all inputs together, so the currents and the switch states describe the same instant. On the following edge the four results are registered. The controller has two states. ST_IDLE waits for the strobe and captures on it (transition IDLE→EVAL). ST_EVAL commits the outputs and always returns (transition EVAL→IDLE). The outputs then hold until the next sample.

Top module: `dqx_frame_xform`

## Requirements
- R1: While reset is held, and after it is released, all four outputs are zero and the controller is in ST_IDLE.
- R2: A strobe seen in ST_IDLE captures i_a, i_b, vdc and sw on that edge. The results appear on the outputs at the next rising edge. Input changes after the capture edge do not affect those results.
- R3: id_o equals i_a (signed, 12 fraction bits), sign-extended from 17 to 18 bits.
- R4: iq_o is bits 35..18 of the signed product of (i_a + 2·i_b) and 151349. The sum is a 19-bit signed value and 151349 is 1/√3 with 18 fraction bits.
- R5: vd_o is bits 27..6 of the signed product vdc·87381·(2·Sa − Sb − Sc). Here vdc is an unsigned integer, 87381 is 1/3 with 18 fraction bits, and Sa, Sb, Sc are sw[0], sw[1], sw[2].
- R6: vq_o is bits 27..6 of the signed product vdc·151349·(Sb − Sc). It is zero whenever Sb equals Sc.
- R7: Between updates all outputs hold their values, whatever the inputs do.
- R8: A strobe that arrives while the controller is in ST_EVAL is ignored.
- R9: Voltage products whose magnitude needs more than bit 27 lose their upper bits. The result is exactly bits 27..6 of the full product, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One-cycle sample strobe |
| i_a | input | 17 | Phase a current, signed, 12 fraction bits |
| i_b | input | 17 | Phase b current, signed, 12 fraction bits |
| vdc | input | 12 | DC-link voltage, unsigned integer |
| sw | input | 3 | Leg states: bit 0 = a, bit 1 = b, bit 2 = c |
| id_o | output | 18 | d-axis current, signed, 12 fraction bits |
| iq_o | output | 18 | q-axis current, signed, 12 fraction bits |
| vd_o | output | 22 | d-axis voltage, signed, 12 fraction bits |
| vq_o | output | 22 | q-axis voltage, signed, 12 fraction bits |

## Verification
The assertions check the control behaviour on every cycle. A strobe in ST_IDLE always leads to ST_EVAL, and ST_EVAL lasts exactly one cycle. Outputs never move outside the commit cycle. The d current follows the captured phase a value, and vq_o is zero when legs b and c match. The exact arithmetic can only be shown by the bench scenarios. These cover the truncated q current over a grid of signed phase currents, both voltages across all eight switch states at several link voltages, and the wrap of large products. Only the scenarios show that a strobe during evaluation is ignored and that inputs changed after capture leave the results alone.

// File: rtl/dqx_pkg.sv
package dqx_pkg;
    localparam int unsigned PH_W      = 17;
    localparam int unsigned IDQ_W     = 18;
    localparam int unsigned K_W       = 19;
    localparam int unsigned K_FRAC    = 18;
    localparam int unsigned VDC_W     = 12;
    localparam int unsigned SW_N      = 3;
    localparam int unsigned VPROD_W   = 34;
    localparam int unsigned VDQ_W     = 22;
    localparam int unsigned VKEEP_LSB = 6;
    localparam int unsigned FACT_W    = 3;

    localparam logic [K_W-1:0] K_RSQRT3 = 19'h24F35;
    localparam logic [K_W-1:0] K_THIRD  = 19'h15555;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } dqx_state_e;
endpackage

// File: rtl/dqx_current_xform.sv
module dqx_current_xform #(
    parameter int unsigned    IN_W   = dqx_pkg::PH_W,
    parameter int unsigned    OUT_W  = dqx_pkg::IDQ_W,
    parameter int unsigned    K_W    = dqx_pkg::K_W,
    parameter int unsigned    K_FRAC = dqx_pkg::K_FRAC,
    parameter logic [K_W-1:0] K      = dqx_pkg::K_RSQRT3
) (
    input  logic [IN_W-1:0]  ph_a,
    input  logic [IN_W-1:0]  ph_b,
    output logic [OUT_W-1:0] d_out,
    output logic [OUT_W-1:0] q_out
);
    localparam int unsigned SUM_W  = IN_W + 2;
    localparam int unsigned PROD_W = SUM_W + K_W;

    logic signed [SUM_W-1:0]  sum_ab;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] sum_x;
    logic signed [PROD_W-1:0] k_x;

    always_comb begin
        sum_ab = $signed({{2{ph_a[IN_W-1]}}, ph_a})
               + $signed({ph_b[IN_W-1], ph_b, 1'b0});
        sum_x  = $signed({{(PROD_W-SUM_W){sum_ab[SUM_W-1]}}, sum_ab});
        k_x    = $signed({{(PROD_W-K_W){K[K_W-1]}}, K});
        prod   = sum_x * k_x;
        q_out  = OUT_W'(prod >>> K_FRAC);
        d_out  = {{(OUT_W-IN_W){ph_a[IN_W-1]}}, ph_a};
    end
endmodule

// File: rtl/dqx_voltage_axis.sv
module dqx_voltage_axis #(
    parameter int unsigned    VDC_W    = dqx_pkg::VDC_W,
    parameter int unsigned    K_W      = dqx_pkg::K_W,
    parameter int unsigned    FACT_W   = dqx_pkg::FACT_W,
    parameter int unsigned    PROD_W   = dqx_pkg::VPROD_W,
    parameter int unsigned    OUT_W    = dqx_pkg::VDQ_W,
    parameter int unsigned    KEEP_LSB = dqx_pkg::VKEEP_LSB,
    parameter logic [K_W-1:0] K        = dqx_pkg::K_THIRD
) (
    input  logic [VDC_W-1:0]         vlink,
    input  logic signed [FACT_W-1:0] factor,
    output logic [OUT_W-1:0]         v_out
);
    logic signed [PROD_W-1:0] vlink_x;
    logic signed [PROD_W-1:0] k_x;
    logic signed [PROD_W-1:0] fact_x;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        vlink_x = $signed({{(PROD_W-VDC_W){1'b0}}, vlink});
        k_x     = $signed({{(PROD_W-K_W){K[K_W-1]}}, K});
        fact_x  = $signed({{(PROD_W-FACT_W){factor[FACT_W-1]}}, factor});
        prod    = vlink_x * k_x * fact_x;
        v_out   = OUT_W'(prod >>> KEEP_LSB);
    end
endmodule

// File: rtl/dqx_frame_xform.sv
module dqx_frame_xform
    import dqx_pkg::*;
#(
    parameter int unsigned IN_W   = PH_W,
    parameter int unsigned IOUT_W = IDQ_W,
    parameter int unsigned V_W    = VDC_W,
    parameter int unsigned VOUT_W = VDQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic [IN_W-1:0]   i_a,
    input  logic [IN_W-1:0]   i_b,
    input  logic [V_W-1:0]    vdc,
    input  logic [SW_N-1:0]   sw,
    output logic [IOUT_W-1:0] id_o,
    output logic [IOUT_W-1:0] iq_o,
    output logic [VOUT_W-1:0] vd_o,
    output logic [VOUT_W-1:0] vq_o
);
    localparam int unsigned AXES = 2;

    dqx_state_e state_q, state_d;

    logic [IN_W-1:0] ia_lat, ib_lat;
    logic [V_W-1:0]  vdc_lat;
    logic [SW_N-1:0] sw_lat;

    logic [IOUT_W-1:0] id_c, iq_c;
    logic signed [FACT_W-1:0] fact [AXES];
    logic [VOUT_W-1:0] v_c [AXES];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sample_stb) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ia_lat  <= '0;
            ib_lat  <= '0;
            vdc_lat <= '0;
            sw_lat  <= '0;
        end else if (state_q == ST_IDLE && sample_stb) begin
            ia_lat  <= i_a;
            ib_lat  <= i_b;
            vdc_lat <= vdc;
            sw_lat  <= sw;
        end
    end

    always_comb begin
        fact[0] = $signed({1'b0, sw_lat[0], 1'b0})
                - $signed({2'b00, sw_lat[1]})
                - $signed({2'b00, sw_lat[2]});
        fact[1] = $signed({2'b00, sw_lat[1]})
                - $signed({2'b00, sw_lat[2]});
    end

    dqx_current_xform #(
        .IN_W  (IN_W),
        .OUT_W (IOUT_W),
        .K_W   (K_W),
        .K_FRAC(K_FRAC),
        .K     (K_RSQRT3)
    ) u_cur (
        .ph_a (ia_lat),
        .ph_b (ib_lat),
        .d_out(id_c),
        .q_out(iq_c)
    );

    for (genvar ax = 0; ax < AXES; ax++) begin : g_axis
        dqx_voltage_axis #(
            .VDC_W   (V_W),
            .K_W     (K_W),
            .FACT_W  (FACT_W),
            .PROD_W  (VPROD_W),
            .OUT_W   (VOUT_W),
            .KEEP_LSB(VKEEP_LSB),
            .K       ((ax == 0) ? K_THIRD : K_RSQRT3)
        ) u_vax (
            .vlink (vdc_lat),
            .factor(fact[ax]),
            .v_out (v_c[ax])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_o <= '0;
            iq_o <= '0;
            vd_o <= '0;
            vq_o <= '0;
        end else if (state_q == ST_EVAL) begin
            id_o <= id_c;
            iq_o <= iq_c;
            vd_o <= v_c[0];
            vq_o <= v_c[1];
        end
    end

    assert_stb_to_eval_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && sample_stb) |=> (state_q == ST_EVAL));

    assert_eval_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL) |=> (state_q == ST_IDLE));

    assert_hold_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_EVAL) |=> ($stable(id_o) && $stable(iq_o)
                                  && $stable(vd_o) && $stable(vq_o)));

    assert_d_follows_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL) |=> ($signed(id_o) == $signed($past(ia_lat))));

    assert_vq_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && sw_lat[1] == sw_lat[2]) |=> (vq_o == '0));
endmodule

// File: tb/dqx_frame_xform_bench.sv
module dqx_frame_xform_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_stb = 1'b0;
    logic [16:0] i_a = '0, i_b = '0;
    logic [11:0] vdc = '0;
    logic [2:0]  sw = '0;
    logic [17:0] id_o, iq_o;
    logic [21:0] vd_o, vq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dqx_frame_xform u_dqx_frame_xform (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
        .i_a(i_a), .i_b(i_b), .vdc(vdc), .sw(sw),
        .id_o(id_o), .iq_o(iq_o), .vd_o(vd_o), .vq_o(vq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] exp_id(input int a);
        logic signed [63:0] p;
        p = 64'(a);
        return p[17:0];
    endfunction

    function automatic logic [17:0] exp_iq(input int a, input int b);
        logic signed [63:0] p;
        p = (64'(a) + 64'(2 * b)) * 64'sd151349;
        return p[35:18];
    endfunction

    function automatic logic [21:0] exp_v(input int v, input int f, input longint k);
        logic signed [63:0] p;
        p = 64'(v) * k * 64'(f);
        return p[27:6];
    endfunction

    logic [17:0] e_id, e_iq;
    logic [21:0] e_vd, e_vq;

    task automatic expect_set(input int a, input int b, input int v, input int s);
        int sa, sb, sc;
        sa = s & 1; sb = (s >> 1) & 1; sc = (s >> 2) & 1;
        e_id = exp_id(a);
        e_iq = exp_iq(a, b);
        e_vd = exp_v(v, 2*sa - sb - sc, 87381);
        e_vq = exp_v(v, sb - sc, 151349);
    endtask

    task automatic check_outs(input string tag);
        chk({"R3 id ", tag}, 32'(id_o), 32'(e_id));
        chk({"R4 iq ", tag}, 32'(iq_o), 32'(e_iq));
        chk({"R5 R9 vd ", tag}, 32'(vd_o), 32'(e_vd));
        chk({"R6 R9 vq ", tag}, 32'(vq_o), 32'(e_vq));
    endtask

    task automatic apply(input int a, input int b, input int v, input int s, input string tag);
        @(negedge clk);
        i_a = 17'(a); i_b = 17'(b); vdc = 12'(v); sw = 3'(s);
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        i_a = ~i_a; i_b = ~i_b; vdc = ~vdc; sw = ~sw;
        @(posedge clk);
        #1;
        expect_set(a, b, v, s);
        check_outs(tag);
    endtask

    initial begin
        int ivals[8] = '{-65536, -40961, -4096, -1, 0, 1, 12345, 65535};
        int vvals[6] = '{0, 1, 311, 540, 700, 4095};

        repeat (3) @(posedge clk);
        #1;
        chk("R1 id reset", 32'(id_o), 0);
        chk("R1 iq reset", 32'(iq_o), 0);
        chk("R1 vd reset", 32'(vd_o), 0);
        chk("R1 vq reset", 32'(vq_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 id after release", 32'(id_o), 0);
        chk("R1 vd after release", 32'(vd_o), 0);

        for (int ia = 0; ia < 8; ia++) begin
            for (int ib = 0; ib < 8; ib++) begin
                apply(ivals[ia], ivals[ib], 100 + 37 * ia, (ia + ib) % 8, "R2 current sweep");
            end
        end

        for (int s = 0; s < 8; s++) begin
            for (int vi = 0; vi < 6; vi++) begin
                apply(1000 * s - 3000, -500 * vi, vvals[vi], s, "voltage sweep");
            end
        end

        apply(20000, -7000, 4095, 1, "R9 wrap vd");
        apply(-1, 1, 4095, 2, "R9 wrap vq");

        apply(4096, 8192, 300, 1, "R7 base");
        @(negedge clk);
        i_a = 17'd777; i_b = 17'd999; vdc = 12'd55; sw = 3'd6;
        repeat (4) @(posedge clk);
        #1;
        check_outs("R7 hold without strobe");

        @(negedge clk);
        i_a = 17'(-2048); i_b = 17'd100; vdc = 12'd400; sw = 3'd3;
        sample_stb = 1'b1;
        @(negedge clk);
        i_a = 17'd30000; i_b = 17'(-30000); vdc = 12'd4000; sw = 3'd4;
        @(negedge clk);
        sample_stb = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        expect_set(-2048, 100, 400, 3);
        check_outs("R8 strobe in eval ignored");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule